// File: doc/BRIEF.md
# Mode-change coherency sequencer

This block sits between a requester and a pseudo-static memory. The memory holds its last asynchronous write in a one-entry buffer and commits it to the array only on the next asynchronous write. Synchronous writes go straight to the array. The sequencer forwards ordinary reads and writes and picks the read and write command flavour that fits the current operating mode. It also accepts mode-change requests and brackets each one with the flush writes the memory needs to stay coherent.

There are three operating modes:
- **Mode 1:** asynchronous read, asynchronous write.
- **Mode 2:** synchronous read, asynchronous write.
- **Mode 3:** synchronous read, synchronous write.

Flush writes around mode changes:
- **Into mode 3:** an asynchronous dummy write is issued first. It pushes the buffered data into the array. Its address and data come from parameters, and the sequencer keeps them in registers.
- **Out of mode 3:** those remembered values are written again synchronously, so that the array and the buffer agree on that location.
- **Between modes 1 and 2:** only the mode-register-set command is sent.

Both the request side and the command side are valid/ready streams:
- **Request side:** a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low whenever the command slot is full and the memory is not taking its content on this edge. `req_ready` is also low for the whole of a mode-change sequence.
- **Command side:** once `cmd_valid` rises, the command fields stay stable and `cmd_valid` stays high until `cmd_ready` is seen high on an edge.

Top module: `mcs_coherency_seq`

## Requirements
- R1: After reset, `cur_mode` is 1, `cmd_valid` is 0 and `req_ready` is 1, and the stored flush address and data equal the parameter defaults (0).
- R2: Read and write requests each produce exactly one command with the request address, on the cycle after acceptance.
  - Request kind codes: 0 read, 1 write, 2 mode change, 3 no-op.
  - Command codes: 0 async read, 1 sync read, 2 async write, 3 sync write, 4 mode-register-set.
  - A read becomes code 0 in mode 1 and code 1 in modes 2 and 3. Its data field is 0.
  - A write becomes code 3 in mode 3 and code 2 otherwise. It carries the request data.
- R3: While `cmd_valid` is high and `cmd_ready` is low, the command fields are held unchanged and `req_ready` is low.
- R4: A change between modes 1 and 2 issues only one mode-register-set command. Its address is 0 and its data holds the target mode in bits [1:0]. `cur_mode` then shows the target.
- R5: A change from mode 1 or 2 into mode 3 issues an asynchronous write of the default flush address and data, then the mode-register-set command. The address and data fields of the request are ignored.
- R6: A change from mode 3 to mode 1 or 2 issues a synchronous write of the stored flush address and data, then the mode-register-set command.
- R7: A mode request for the current mode or for code 0, and a no-op request, are accepted without any command, and `cur_mode` is unchanged.
- R8: From the acceptance of a real mode change until the mode-register-set command is taken by the memory, `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this edge |
| req_kind | input | 2 | 0 read, 1 write, 2 mode change, 3 no-op |
| req_mode | input | 2 | Target mode for a mode change (1..3; 0 = none) |
| req_addr | input | AW | Request address |
| req_data | input | DW | Request write data |
| cmd_valid | output | 1 | Command present toward memory |
| cmd_ready | input | 1 | Memory takes the command this edge |
| cmd_op | output | 3 | Command code (see R2) |
| cmd_addr | output | AW | Command address |
| cmd_data | output | DW | Command write data or target mode |
| cur_mode | output | 2 | Mode the memory is currently set to |

## Verification
The following are checked by assertions on every cycle:
- the command hold rule under back-pressure;
- that synchronous writes only appear in mode 3 and asynchronous reads only in mode 1;
- that every mode-register-set into mode 3 is preceded by an asynchronous write, and every one out of mode 3 by a synchronous write;
- that the flush registers do not move while in mode 3;
- that `req_ready` drops after a real mode change is accepted.

Only the bench scenarios can show three things:
- that the exact addresses and data of the flush writes are right;
- that no-change requests leave the command stream silent;
- that a full round trip through all three modes yields the correct ordered command list.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [1:0] {
    K_READ  = 2'd0,
    K_WRITE = 2'd1,
    K_MODE  = 2'd2,
    K_NOP   = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    OP_RD_ASYNC = 3'd0,
    OP_RD_SYNC  = 3'd1,
    OP_WR_ASYNC = 3'd2,
    OP_WR_SYNC  = 3'd3,
    OP_MRS      = 3'd4
  } cmd_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ENTRY = 2'd1,
    ST_EXIT  = 2'd2,
    ST_MRS   = 2'd3
  } seq_state_e;

  localparam logic [1:0] MODE_NONE = 2'd0;
  localparam logic [1:0] MODE_AA   = 2'd1;
  localparam logic [1:0] MODE_SA   = 2'd2;
  localparam logic [1:0] MODE_SS   = 2'd3;

  // Read flavour follows the read half of the mode.
  function automatic cmd_op_e read_op(input logic [1:0] mode);
    return (mode == MODE_AA) ? OP_RD_ASYNC : OP_RD_SYNC;
  endfunction

  // Only the fully synchronous mode writes synchronously.
  function automatic cmd_op_e write_op(input logic [1:0] mode);
    return (mode == MODE_SS) ? OP_WR_SYNC : OP_WR_ASYNC;
  endfunction

endpackage

// File: rtl/mcs_cmd_slot.sv
module mcs_cmd_slot
  import mcs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  cmd_op_e       ld_op,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          cmd_ready,
  output logic          cmd_valid,
  output logic [2:0]    cmd_op,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          slot_free
);

  assign slot_free = !cmd_valid || cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_op    <= '0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else if (load) begin
      cmd_valid <= 1'b1;
      cmd_op    <= ld_op;
      cmd_addr  <= ld_addr;
      cmd_data  <= ld_data;
    end else if (cmd_ready) begin
      cmd_valid <= 1'b0;
    end
  end

  // R3: a stalled command keeps its content
  assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) &&
                                   $stable(cmd_addr) && $stable(cmd_data)));

  // R3: nothing is pushed into an occupied, stalled slot
  assert_no_overwrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> slot_free);

endmodule

// File: rtl/mcs_flush_store.sv
module mcs_flush_store
  import mcs_pkg::*;
#(
  parameter int          AW         = 16,
  parameter int          DW         = 16,
  parameter logic [AW-1:0] DUMMY_ADDR = '0,
  parameter logic [DW-1:0] DUMMY_DATA = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [1:0]    mode_now,
  output logic [AW-1:0] saved_addr,
  output logic [DW-1:0] saved_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      saved_addr <= DUMMY_ADDR;
      saved_data <= DUMMY_DATA;
    end else if (capture) begin
      saved_addr <= DUMMY_ADDR;
      saved_data <= DUMMY_DATA;
    end
  end

  // R6: the entry flush pattern survives the whole stay in mode 3
  assert_store_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == MODE_SS) |=> ($stable(saved_addr) && $stable(saved_data)));

  // R5: a capture only happens outside mode 3
  assert_capture_outside_R5: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (mode_now != MODE_SS));

endmodule

// File: rtl/mcs_seq_fsm.sv
module mcs_seq_fsm
  import mcs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [1:0]    req_mode,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          slot_free,
  input  logic [AW-1:0] saved_addr,
  input  logic [DW-1:0] saved_data,
  output logic          req_ready,
  output logic          load,
  output cmd_op_e       ld_op,
  output logic [AW-1:0] ld_addr,
  output logic [DW-1:0] ld_data,
  output logic          capture,
  output logic [1:0]    cur_mode
);

  seq_state_e state, nxt_state;
  logic [1:0] tgt_q, nxt_tgt, nxt_mode;
  logic       accept;
  logic       real_change;

  assign req_ready   = (state == ST_IDLE) && slot_free;
  assign accept      = req_valid && req_ready;
  assign real_change = (req_mode != MODE_NONE) && (req_mode != cur_mode);

  always_comb begin
    load      = 1'b0;
    ld_op     = OP_RD_ASYNC;
    ld_addr   = '0;
    ld_data   = '0;
    capture   = 1'b0;
    nxt_state = state;
    nxt_tgt   = tgt_q;
    nxt_mode  = cur_mode;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          unique case (req_kind_e'(req_kind))
            K_READ: begin
              load    = 1'b1;
              ld_op   = read_op(cur_mode);
              ld_addr = req_addr;
            end
            K_WRITE: begin
              load    = 1'b1;
              ld_op   = write_op(cur_mode);
              ld_addr = req_addr;
              ld_data = req_data;
            end
            K_MODE: begin
              if (real_change) begin
                nxt_tgt = req_mode;
                if (req_mode == MODE_SS) begin
                  nxt_state = ST_ENTRY;
                  capture   = 1'b1;
                end else if (cur_mode == MODE_SS) begin
                  nxt_state = ST_EXIT;
                end else begin
                  nxt_state = ST_MRS;
                end
              end
            end
            default: ;
          endcase
        end
      end
      ST_ENTRY: begin
        if (slot_free) begin
          load      = 1'b1;
          ld_op     = OP_WR_ASYNC;
          ld_addr   = saved_addr;
          ld_data   = saved_data;
          nxt_state = ST_MRS;
        end
      end
      ST_EXIT: begin
        if (slot_free) begin
          load      = 1'b1;
          ld_op     = OP_WR_SYNC;
          ld_addr   = saved_addr;
          ld_data   = saved_data;
          nxt_state = ST_MRS;
        end
      end
      ST_MRS: begin
        if (slot_free) begin
          load      = 1'b1;
          ld_op     = OP_MRS;
          ld_data   = {{(DW-2){1'b0}}, tgt_q};
          nxt_mode  = tgt_q;
          nxt_state = ST_IDLE;
        end
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      tgt_q    <= MODE_AA;
      cur_mode <= MODE_AA;
    end else begin
      state    <= nxt_state;
      tgt_q    <= nxt_tgt;
      cur_mode <= nxt_mode;
    end
  end

  // Checker state: last command pushed toward the slot.
  cmd_op_e last_ld_op;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_ld_op <= OP_RD_ASYNC;
    else if (load) last_ld_op <= ld_op;
  end

  // R5: entering mode 3 is preceded by an asynchronous flush write
  assert_entry_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ld_op == OP_MRS && ld_data[1:0] == MODE_SS) |-> (last_ld_op == OP_WR_ASYNC));

  // R6: leaving mode 3 is preceded by a synchronous replay write
  assert_exit_replay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ld_op == OP_MRS && cur_mode == MODE_SS) |-> (last_ld_op == OP_WR_SYNC));

  // R8: a real mode change closes the request port on the next cycle
  assert_stall_after_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_kind == K_MODE && real_change) |=> !req_ready);

  // R1: mode register never holds the unused code
  assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cur_mode != MODE_NONE);

endmodule

// File: rtl/mcs_coherency_seq.sv
module mcs_coherency_seq
  import mcs_pkg::*;
#(
  parameter int            AW         = 16,
  parameter int            DW         = 16,
  parameter logic [AW-1:0] DUMMY_ADDR = '0,
  parameter logic [DW-1:0] DUMMY_DATA = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [1:0]    req_mode,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [2:0]    cmd_op,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic [1:0]    cur_mode
);

  logic          load, capture, slot_free;
  cmd_op_e       ld_op;
  logic [AW-1:0] ld_addr, saved_addr;
  logic [DW-1:0] ld_data, saved_data;

  mcs_seq_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .req_mode   (req_mode),
    .req_addr   (req_addr),
    .req_data   (req_data),
    .slot_free  (slot_free),
    .saved_addr (saved_addr),
    .saved_data (saved_data),
    .req_ready  (req_ready),
    .load       (load),
    .ld_op      (ld_op),
    .ld_addr    (ld_addr),
    .ld_data    (ld_data),
    .capture    (capture),
    .cur_mode   (cur_mode)
  );

  mcs_flush_store #(
    .AW(AW), .DW(DW), .DUMMY_ADDR(DUMMY_ADDR), .DUMMY_DATA(DUMMY_DATA)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (capture),
    .mode_now   (cur_mode),
    .saved_addr (saved_addr),
    .saved_data (saved_data)
  );

  mcs_cmd_slot #(.AW(AW), .DW(DW)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .ld_op     (ld_op),
    .ld_addr   (ld_addr),
    .ld_data   (ld_data),
    .cmd_ready (cmd_ready),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .slot_free (slot_free)
  );

  // R2: synchronous writes are only presented while in mode 3
  assert_sync_write_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_WR_SYNC) |-> (cur_mode == MODE_SS));

  // R2: asynchronous reads are only presented while in mode 1
  assert_async_read_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_RD_ASYNC) |-> (cur_mode == MODE_AA));

  // R2: no command code beyond the defined set
  assert_op_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_op <= OP_MRS));

endmodule

// File: tb/mcs_coherency_seq_tb_top.sv
module mcs_coherency_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'd0;
  logic [1:0]  req_mode = 2'd0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b1;
  logic [2:0]  cmd_op;
  logic [15:0] cmd_addr;
  logic [15:0] cmd_data;
  logic [1:0]  cur_mode;

  always #4 clk = ~clk;  // 125 MHz

  mcs_coherency_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_mode(req_mode), .req_addr(req_addr), .req_data(req_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cur_mode(cur_mode)
  );

  int checks = 0;
  int errors = 0;

  // Captured command handshakes
  logic [2:0]  cap_op [4];
  logic [15:0] cap_a  [4];
  logic [15:0] cap_d  [4];
  int          cap_n = 0;

  always @(negedge clk) begin
    if (rst_n && cmd_valid && cmd_ready) begin
      if (cap_n < 4) begin
        cap_op[cap_n] = cmd_op;
        cap_a[cap_n]  = cmd_addr;
        cap_d[cap_n]  = cmd_data;
      end
      cap_n = cap_n + 1;
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] k, input logic [1:0] m,
                      input logic [15:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    req_valid = 1'b1; req_kind = k; req_mode = m; req_addr = a; req_data = d;
    for (int t = 0; t < 50; t++) begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int t = 0; t < 30; t++) begin
      @(negedge clk);
      if (req_ready && !cmd_valid) break;
    end
  endtask

  // Codes: kind 0 rd,1 wr,2 mode,3 nop; op 0 RDA,1 RDS,2 WRA,3 WRS,4 MRS
  typedef struct packed {
    logic [1:0]  kind;
    logic [1:0]  mode;
    logic [15:0] addr;
    logic [15:0] data;
    logic [1:0]  n;
    logic [2:0]  op0;
    logic [15:0] a0;
    logic [15:0] d0;
    logic [2:0]  op1;
    logic [15:0] a1;
    logic [15:0] d1;
    logic [1:0]  mode_after;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{2'd1, 2'd0, 16'h0000, 16'h1111, 2'd1, 3'd2, 16'h0000, 16'h1111, 3'd0, 16'h0, 16'h0, 2'd1, 4'd2}, // R2 async write
    '{2'd0, 2'd0, 16'h0000, 16'h9999, 2'd1, 3'd0, 16'h0000, 16'h0000, 3'd0, 16'h0, 16'h0, 2'd1, 4'd2}, // R2 async read
    '{2'd2, 2'd2, 16'hBEEF, 16'h7777, 2'd1, 3'd4, 16'h0000, 16'h0002, 3'd0, 16'h0, 16'h0, 2'd2, 4'd4}, // R4 1->2
    '{2'd0, 2'd0, 16'h0005, 16'h0000, 2'd1, 3'd1, 16'h0005, 16'h0000, 3'd0, 16'h0, 16'h0, 2'd2, 4'd2}, // R2 sync read
    '{2'd1, 2'd0, 16'h0001, 16'h5555, 2'd1, 3'd2, 16'h0001, 16'h5555, 3'd0, 16'h0, 16'h0, 2'd2, 4'd2}, // R2 write in mode 2
    '{2'd2, 2'd3, 16'hBEEF, 16'h7777, 2'd2, 3'd2, 16'h0000, 16'h0000, 3'd4, 16'h0, 16'h3, 2'd3, 4'd5}, // R5 2->3
    '{2'd1, 2'd0, 16'hFFFF, 16'h5555, 2'd1, 3'd3, 16'hFFFF, 16'h5555, 3'd0, 16'h0, 16'h0, 2'd3, 4'd2}, // R2 sync write
    '{2'd0, 2'd0, 16'hFFFF, 16'h0000, 2'd1, 3'd1, 16'hFFFF, 16'h0000, 3'd0, 16'h0, 16'h0, 2'd3, 4'd2}, // R2 read mode 3
    '{2'd2, 2'd3, 16'h1234, 16'h4321, 2'd0, 3'd0, 16'h0000, 16'h0000, 3'd0, 16'h0, 16'h0, 2'd3, 4'd7}, // R7 same mode
    '{2'd2, 2'd1, 16'hBEEF, 16'h7777, 2'd2, 3'd3, 16'h0000, 16'h0000, 3'd4, 16'h0, 16'h1, 2'd1, 4'd6}, // R6 3->1
    '{2'd0, 2'd0, 16'h1234, 16'h0000, 2'd1, 3'd0, 16'h1234, 16'h0000, 3'd0, 16'h0, 16'h0, 2'd1, 4'd2}, // R2 read mode 1
    '{2'd2, 2'd1, 16'h0000, 16'h0000, 2'd0, 3'd0, 16'h0000, 16'h0000, 3'd0, 16'h0, 16'h0, 2'd1, 4'd7}, // R7 same mode
    '{2'd2, 2'd0, 16'h0000, 16'h0000, 2'd0, 3'd0, 16'h0000, 16'h0000, 3'd0, 16'h0, 16'h0, 2'd1, 4'd7}, // R7 code 0
    '{2'd3, 2'd2, 16'hABCD, 16'h1111, 2'd0, 3'd0, 16'h0000, 16'h0000, 3'd0, 16'h0, 16'h0, 2'd1, 4'd7}, // R7 no-op
    '{2'd2, 2'd2, 16'h0000, 16'h0000, 2'd1, 3'd4, 16'h0000, 16'h0002, 3'd0, 16'h0, 16'h0, 2'd2, 4'd4}, // R4 1->2
    '{2'd2, 2'd1, 16'h0000, 16'h0000, 2'd1, 3'd4, 16'h0000, 16'h0001, 3'd0, 16'h0, 16'h0, 2'd1, 4'd4}, // R4 2->1
    '{2'd2, 2'd3, 16'h5A5A, 16'hA5A5, 2'd2, 3'd2, 16'h0000, 16'h0000, 3'd4, 16'h0, 16'h3, 2'd3, 4'd5}, // R5 1->3
    '{2'd2, 2'd2, 16'h5A5A, 16'hA5A5, 2'd2, 3'd3, 16'h0000, 16'h0000, 3'd4, 16'h0, 16'h2, 2'd2, 4'd6}, // R6 3->2
    '{2'd1, 2'd0, 16'h0777, 16'h0888, 2'd1, 3'd2, 16'h0777, 16'h0888, 3'd0, 16'h0, 16'h0, 2'd2, 4'd2}  // R2 write mode 2
  };

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] held_a;
    vec_t v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(cur_mode == 2'd1, "R1 reset mode", cur_mode, 1);
    check(cmd_valid == 1'b0, "R1 reset cmd_valid", cmd_valid, 0);
    check(req_ready == 1'b1, "R1 reset req_ready", req_ready, 1);

    for (int i = 0; i < NV; i++) begin
      v = TBL[i];
      cap_n = 0;
      send(v.kind, v.mode, v.addr, v.data);
      wait_idle();
      check(cap_n == int'(v.n), $sformatf("R%0d vec %0d count", v.req, i), cap_n, v.n);
      if (v.n >= 1) begin
        check(cap_op[0] == v.op0, $sformatf("R%0d vec %0d op0", v.req, i), cap_op[0], v.op0);
        check(cap_a[0] == v.a0, $sformatf("R%0d vec %0d addr0", v.req, i), cap_a[0], v.a0);
        check(cap_d[0] == v.d0, $sformatf("R%0d vec %0d data0", v.req, i), cap_d[0], v.d0);
      end
      if (v.n >= 2) begin
        check(cap_op[1] == v.op1, $sformatf("R%0d vec %0d op1", v.req, i), cap_op[1], v.op1);
        check(cap_a[1] == v.a1, $sformatf("R%0d vec %0d addr1", v.req, i), cap_a[1], v.a1);
        check(cap_d[1] == v.d1, $sformatf("R%0d vec %0d data1", v.req, i), cap_d[1], v.d1);
      end
      check(cur_mode == v.mode_after, $sformatf("R%0d vec %0d mode", v.req, i), cur_mode, v.mode_after);
    end

    // R3: back-pressure on the command stream, now in mode 2
    cmd_ready = 1'b0;
    cap_n = 0;
    send(2'd1, 2'd0, 16'h0042, 16'h0099);
    @(negedge clk);
    check(cmd_valid == 1'b1, "R3 stalled valid", cmd_valid, 1);
    check(cmd_op == 3'd2, "R3 stalled op", cmd_op, 2);
    check(req_ready == 1'b0, "R3 ready low when full", req_ready, 0);
    held_a = cmd_addr;
    repeat (3) begin
      @(negedge clk);
      check(cmd_addr == held_a && cmd_addr == 16'h0042, "R3 addr held", cmd_addr, 16'h0042);
      check(req_ready == 1'b0, "R3 ready held low", req_ready, 0);
    end
    @(posedge clk); #1 cmd_ready = 1'b1;
    wait_idle();
    check(cap_n == 1, "R3 single handshake", cap_n, 1);

    // R8: ready low through a stalled entry sequence (mode 2 -> 3)
    cmd_ready = 1'b0;
    cap_n = 0;
    send(2'd2, 2'd3, 16'h1111, 16'h2222);
    repeat (4) begin
      @(negedge clk);
      check(req_ready == 1'b0, "R8 ready low in sequence", req_ready, 0);
    end
    check(cmd_valid && cmd_op == 3'd2 && cmd_addr == 16'h0000, "R5 flush presented first", cmd_op, 2);
    @(posedge clk); #1 cmd_ready = 1'b1;
    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      if (cmd_valid && cmd_op != 3'd4)
        check(req_ready == 1'b0, "R8 ready before MRS", req_ready, 0);
      if (!cmd_valid) break;
    end
    check(cap_n == 2 && cap_op[1] == 3'd4, "R8 sequence completes with MRS", cap_op[1], 4);
    check(cur_mode == 2'd3, "R5 mode after stall", cur_mode, 3);

    // R1: reset from mode 3 returns to mode 1
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(cur_mode == 2'd1, "R1 re-reset mode", cur_mode, 1);
    check(cmd_valid == 1'b0 && req_ready == 1'b1, "R1 re-reset handshake", {cmd_valid, req_ready}, 1);

    // R1: stored flush pattern is default after reset; exit replays it
    send(2'd2, 2'd3, 16'h3333, 16'h4444);
    wait_idle();
    cap_n = 0;
    send(2'd2, 2'd1, 16'h3333, 16'h4444);
    wait_idle();
    check(cap_n == 2 && cap_op[0] == 3'd3 && cap_a[0] == 16'h0 && cap_d[0] == 16'h0,
          "R6 replay after reset", cap_a[0], 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule